// File: doc/BRIEF.md
# Drive Level Adjustment Unit

During serial link training, a receiver reports a requested output swing and a requested pre-emphasis for each lane. This unit combines those per-lane requests into one drive setting that is applied to every lane. It uses the worst case across the lanes that are in use. It then limits the result to what the upstream transmitter can produce, and it respects the rule that a higher pre-emphasis leaves less room for swing.

The result is packed into a setting byte. The byte carries the two levels and two saturation flags, which the training sequencer uses to stop retrying once a limit is hit. The byte is repeated in four lane slots. A one-cycle start strobe launches an evaluation. The result and a done pulse appear on registered outputs one clock later, and they stay unchanged until the next strobe.

Top module: `drive_level_adjust`

## Requirements
- R1: The chosen swing is the largest swing request among the active lanes. Lane i is active when i < `lane_cnt`, and lane i's swing request is at `swing_req[2i+1:2i]`.
- R2: The chosen pre-emphasis is the largest pre-emphasis request among the active lanes. Lane i's pre-emphasis request is at `pre_req[2i+1:2i]`.
- R3: Requests on inactive lanes have no effect on the result, whatever their values.
- R4: If the chosen pre-emphasis is greater than or equal to `pre_max`, it is replaced by `pre_max` and the pre-emphasis saturation flag is set. Otherwise that flag is clear.
- R5: The swing is then limited so that swing plus pre-emphasis does not exceed 3. Pre-emphasis 0, 1, 2 and 3 allow swing up to 3, 2, 1 and 0 respectively.
- R6: If the limited swing is greater than or equal to `swing_max`, it is replaced by `swing_max` and the swing saturation flag is set. Otherwise that flag is clear. Supported maxima are 2 or 3 for both quantities.
- R7: Setting byte layout: bits [1:0] hold the swing, bit 2 is the swing saturation flag, bits [4:3] hold the pre-emphasis, bit 5 is the pre-emphasis saturation flag, and bits [7:6] are 0. The same byte appears in all four slots `lane_set[8i+7:8i]`, regardless of `lane_cnt`.
- R8: `lane_set` and `done` update on the first rising edge after `start` is sampled high. `done` is high for exactly the cycles that follow a cycle with `start` high.
- R9: When `start` is low, `lane_set` holds its value even if the request or limit inputs change.
- R10: Synchronous active-high `rst` clears `lane_set` to 0 and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the current requests |
| lane_cnt | input | 3 | Number of active lanes (1, 2 or 4) |
| swing_req | input | 8 | Per-lane swing requests, 2 bits each |
| pre_req | input | 8 | Per-lane pre-emphasis requests, 2 bits each |
| swing_max | input | 2 | Largest swing the transmitter supports |
| pre_max | input | 2 | Largest pre-emphasis the transmitter supports |
| lane_set | output | 32 | Four identical lane setting bytes |
| done | output | 1 | Result valid pulse |

## Verification
The hardest case to reach is the interaction of the three limits in sequence. A pre-emphasis clamp must shrink the room for swing so that a large swing request ends up below `swing_max`, leaving the swing flag clear while the pre-emphasis flag is set. The stimulus table builds this case on purpose, by pairing full-scale swing requests with clamped pre-emphasis. It also places the largest requests on lanes that `lane_cnt` excludes, so that any leak from an inactive lane changes the expected byte. Directed steps change every input without a strobe, to show that the output holds.

// File: rtl/drive_adj_pkg.sv
package drive_adj_pkg;
  localparam int LVL_W = 2;
  localparam int LANES = 4;

  typedef struct packed {
    logic [1:0]       rsvd;
    logic             pre_hit;
    logic [LVL_W-1:0] pre;
    logic             swing_hit;
    logic [LVL_W-1:0] swing;
  } lane_setting_t;
endpackage

// File: rtl/drive_req_peak.sv
module drive_req_peak #(
  parameter int LANES = 4,
  parameter int LVL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [LANES*LVL_W-1:0] req,
  input  logic [CNT_W-1:0]       lane_cnt,
  output logic [LVL_W-1:0]       peak
);
  always_comb begin
    peak = '0;
    for (int i = 0; i < LANES; i++) begin
      if ((CNT_W'(i) < lane_cnt) && (req[i*LVL_W +: LVL_W] > peak))
        peak = req[i*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/drive_level_clamp.sv
module drive_level_clamp
  import drive_adj_pkg::*;
(
  input  logic [LVL_W-1:0] swing_in,
  input  logic [LVL_W-1:0] pre_in,
  input  logic [LVL_W-1:0] swing_max,
  input  logic [LVL_W-1:0] pre_max,
  output lane_setting_t    setting
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  logic [LVL_W-1:0] pre_c;
  logic             pre_hit;
  logic [LVL_W-1:0] room;
  logic [LVL_W-1:0] swing_room;

  always_comb begin
    pre_hit    = (pre_in >= pre_max);
    pre_c      = pre_hit ? pre_max : pre_in;
    room       = TOP_LVL - pre_c;
    swing_room = (swing_in > room) ? room : swing_in;
    setting.rsvd      = 2'b00;
    setting.pre       = pre_c;
    setting.pre_hit   = pre_hit;
    setting.swing_hit = (swing_room >= swing_max);
    setting.swing     = setting.swing_hit ? swing_max : swing_room;
  end
endmodule

// File: rtl/drive_level_adjust.sv
module drive_level_adjust
  import drive_adj_pkg::*;
#(
  parameter int NLANES = LANES,
  localparam int CNT_W = $clog2(NLANES) + 1,
  localparam int REQ_W = NLANES * LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   lane_cnt,
  input  logic [REQ_W-1:0]   swing_req,
  input  logic [REQ_W-1:0]   pre_req,
  input  logic [LVL_W-1:0]   swing_max,
  input  logic [LVL_W-1:0]   pre_max,
  output logic [NLANES*8-1:0] lane_set,
  output logic               done
);
  logic [LVL_W-1:0] swing_peak;
  logic [LVL_W-1:0] pre_peak;
  lane_setting_t    next_set;

  drive_req_peak #(.LANES(NLANES), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_swing_peak (
    .req(swing_req), .lane_cnt(lane_cnt), .peak(swing_peak)
  );

  drive_req_peak #(.LANES(NLANES), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_pre_peak (
    .req(pre_req), .lane_cnt(lane_cnt), .peak(pre_peak)
  );

  drive_level_clamp u_clamp (
    .swing_in(swing_peak), .pre_in(pre_peak),
    .swing_max(swing_max), .pre_max(pre_max),
    .setting(next_set)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        lane_set[g*8 +: 8] <= '0;
      else if (start)
        lane_set[g*8 +: 8] <= next_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= start;
  end
endmodule

// File: rtl/drive_level_adjust_chk.sv
module drive_level_adjust_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [1:0]  swing_max,
  input logic [1:0]  pre_max,
  input logic [31:0] lane_set,
  input logic        done
);
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_done_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(lane_set));
  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst)
    lane_set[7:6] == 2'b00);
  assert_level_sum_R5: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, lane_set[1:0]} + {1'b0, lane_set[4:3]}) <= 3'd3);
  assert_pre_flag_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> (!lane_set[5] || (lane_set[4:3] == $past(pre_max))));
  assert_swing_flag_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (!lane_set[2] || (lane_set[1:0] == $past(swing_max))));
endmodule

bind drive_level_adjust drive_level_adjust_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .swing_max(swing_max),
  .pre_max(pre_max), .lane_set(lane_set), .done(done)
);

// File: tb/drive_level_adjust_bench.sv
`timescale 1ns/1ps
module drive_level_adjust_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  lane_cnt = 3'd4;
  logic [7:0]  swing_req = '0;
  logic [7:0]  pre_req = '0;
  logic [1:0]  swing_max = 2'd3;
  logic [1:0]  pre_max = 2'd3;
  logic [31:0] lane_set;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  drive_level_adjust u_drive_level_adjust (
    .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt),
    .swing_req(swing_req), .pre_req(pre_req), .swing_max(swing_max),
    .pre_max(pre_max), .lane_set(lane_set), .done(done)
  );

  // {lane_cnt, swing_req, pre_req, swing_max, pre_max, expected byte}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {3'd4, 8'b00_01_00_00, 8'b00_00_00_00, 2'd3, 2'd3, 8'h01}, // R1 peak on lane 2
    {3'd4, 8'b11_00_00_00, 8'b00_00_00_00, 2'd3, 2'd3, 8'h07}, // R6 swing hits 3
    {3'd1, 8'b11_11_11_01, 8'b11_11_11_00, 2'd3, 2'd3, 8'h01}, // R3 one lane
    {3'd2, 8'b11_11_10_01, 8'b11_11_01_00, 2'd3, 2'd3, 8'h0A}, // R2 two lanes
    {3'd4, 8'b11_11_11_11, 8'b00_00_00_10, 2'd3, 2'd2, 8'h31}, // R4 R5 pre clamp limits swing
    {3'd4, 8'b00_00_00_00, 8'b11_00_00_00, 2'd2, 2'd3, 8'h38}, // R4 pre 3
    {3'd2, 8'b00_00_10_00, 8'b00_00_00_00, 2'd2, 2'd3, 8'h06}, // R6 equal to max
    {3'd4, 8'b00_00_00_11, 8'b00_00_00_00, 2'd2, 2'd3, 8'h06}, // R6 above max
    {3'd4, 8'b10_00_00_00, 8'b00_01_00_00, 2'd2, 2'd2, 8'h0E}, // R5 R6 cap then clamp
    {3'd1, 8'b11_11_11_00, 8'b10_10_10_00, 2'd2, 2'd2, 8'h00}, // R3 all inactive high
    {3'd2, 8'b00_11_00_00, 8'b11_00_00_00, 2'd3, 2'd3, 8'h00}, // R3 lanes 2,3 ignored
    {3'd4, 8'b00_00_00_10, 8'b00_00_10_00, 2'd3, 2'd3, 8'h11}  // R5 pre 2 caps swing 2
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [30:0] v);
    @(negedge clk);
    lane_cnt  = v[30:28];
    swing_req = v[27:20];
    pre_req   = v[19:12];
    swing_max = v[11:10];
    pre_max   = v[9:8];
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check32("R10 reset lane_set", lane_set, 32'h0);
    check32("R10 reset done", {31'b0, done}, 32'h1 & 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check32($sformatf("R7 vector %0d lane_set", i), lane_set, {4{VEC[i][7:0]}});
      check32("R8 done after start", {31'b0, done}, 32'h1);
    end

    @(negedge clk);
    check32("R8 done single pulse", {31'b0, done}, 32'h0);

    // R9: change every input without a strobe
    lane_cnt = 3'd4; swing_req = 8'hFF; pre_req = 8'h00; swing_max = 2'd2; pre_max = 2'd2;
    repeat (3) @(negedge clk);
    check32("R9 hold without start", lane_set, {4{8'h11}});

    // R8: back-to-back strobes keep done high and take the newest inputs
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check32("R8 first of two", lane_set, {4{8'h06}});
    swing_req = 8'h00; pre_req = 8'h00;
    @(negedge clk);
    start = 1'b0;
    check32("R8 second of two", lane_set, {4{8'h00}});
    check32("R8 done stays high", {31'b0, done}, 32'h1);

    // R10: reset mid-run clears the result
    apply({3'd4, 8'hFF, 8'h00, 2'd3, 2'd3, 8'h07});
    rst = 1'b1;
    @(negedge clk);
    check32("R10 reset after result", lane_set, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule